// File: doc/BRIEF.md
# Configuration Invalidation Dispatcher

This block sits behind a command queue. It takes one configuration-invalidate command at a time and sends invalidation requests to every cache that holds stream configuration. That set is the shared configuration cache plus the micro TLB and the main TLB of each device port. All of them receive the same request on one broadcast bus. A request moves only in a cycle where every target signals ready, so a stale translation cannot survive in a per-port TLB after the shared cache has dropped the matching configuration.

The block decodes five kinds of command:

- Purge one stream.
- Purge one stream and substream pair.
- Purge all contexts of one stream. This is a stream-wide purge.
- Purge an aligned block of streams. The sequencer walks this block one stream ID per transfer.
- Purge everything. This is a block command with the all-ones range value.

Commands with an unrecognised opcode are consumed and flagged. While a command is being worked off the queue is held off, and it is released once the final request has been taken.

Top module: `cfgi_dispatch`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cmd_ready` is 1, `inv_valid` is 0 and `cmd_err` is 0.
- R2: Opcode 8'h03 (single stream) produces exactly one request with `inv_kind` 0 (stream) and `inv_sid` equal to the command's stream ID.
- R3: Opcode 8'h05 (stream plus substream) produces exactly one request with `inv_kind` 1 (context). It carries both `inv_sid` and `inv_ssid` from the command.
- R4: Opcode 8'h06 (all contexts of a stream) produces exactly one request with `inv_kind` 0 (stream) for the command's stream ID.
- R5: Opcode 8'h04 with a range value r below 31 produces stream requests (`inv_kind` 0). The first is for the command's stream ID with its low r+1 bits cleared. Each following request is for the next ID, up to the first plus 2^(r+1)−1. When r+1 reaches the stream ID width, every ID from 0 to the maximum is covered.
- R6: Opcode 8'h04 with range value 31 produces exactly one request with `inv_kind` 2 (everything).
- R7: A request is taken only in a cycle where all bits of `tgt_ready` are 1. Until then, `inv_valid` stays high and the request fields stay unchanged. When targets stay ready, a new request is offered every cycle.
- R8: `cmd_ready` is 0 from the cycle after a valid command is accepted until its last request is taken. It is 1 again in the following cycle. An accepted valid command yields `inv_valid` in the next cycle.
- R9: A command with any other opcode is accepted without producing a request. `cmd_err` pulses high for exactly the one cycle after acceptance, and `cmd_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Dispatcher can accept a command |
| cmd_op | input | 8 | Command opcode |
| cmd_sid | input | SID_W | Stream ID of the command |
| cmd_ssid | input | SSID_W | Substream ID of the command |
| cmd_range | input | 5 | Block size exponent minus one; 31 means everything |
| inv_valid | output | 1 | Broadcast request present |
| inv_kind | output | 2 | 0 stream, 1 context, 2 everything |
| inv_sid | output | SID_W | Stream ID of the request |
| inv_ssid | output | SSID_W | Substream ID, meaningful for context requests |
| tgt_ready | input | 2*NUM_PORTS+1 | Per-target ready: bit 0 configuration cache, bits 1..NUM_PORTS micro TLBs, the rest main TLBs |
| cmd_err | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
The hardest case to reach is a block walk where targets drop ready at scattered points. The drops can hit the first ID, the middle of the walk or the final ID. At those points an off-by-one in hold or in termination would shift or lose a stream. The stimulus reaches it by redrawing every bit of `tgt_ready` from a seeded generator on every cycle of a walk. Block commands are mixed with small and saturating ranges, and directed cases cover a two-stream block at an odd ID and a walk of the whole ID space.

// File: rtl/cfgi_pkg.sv
package cfgi_pkg;

    localparam int OP_W    = 8;
    localparam int RANGE_W = 5;
    localparam logic [RANGE_W-1:0] RANGE_EVERY = 5'd31;

    typedef enum logic [OP_W-1:0] {
        OPC_STREAM       = 8'h03,
        OPC_STREAM_BLOCK = 8'h04,
        OPC_CONTEXT      = 8'h05,
        OPC_STREAM_CTXS  = 8'h06
    } cfgi_op_e;

    typedef enum logic [1:0] {
        INV_STREAM  = 2'd0,
        INV_CONTEXT = 2'd1,
        INV_EVERY   = 2'd2
    } inv_kind_e;

    typedef struct packed {
        logic      known;
        inv_kind_e kind;
    } cfgi_dec_t;

    function automatic logic range_is_every(input logic [RANGE_W-1:0] r);
        return r == RANGE_EVERY;
    endfunction

endpackage

// File: rtl/cfgi_decode.sv
module cfgi_decode
    import cfgi_pkg::*;
#(
    parameter int SID_W = 8
) (
    input  logic [OP_W-1:0]    op,
    input  logic [SID_W-1:0]   sid,
    input  logic [RANGE_W-1:0] rng,
    output cfgi_dec_t          dec,
    output logic [SID_W-1:0]   first_sid,
    output logic [SID_W-1:0]   last_sid
);

    logic [SID_W-1:0] blk_mask;

    // Bit i of the mask is set when i falls inside the low rng+1 bits.
    for (genvar i = 0; i < SID_W; i++) begin : g_mask
        assign blk_mask[i] = (32'(rng) >= i);
    end

    always_comb begin
        dec.known = 1'b1;
        dec.kind  = INV_STREAM;
        first_sid = sid;
        last_sid  = sid;
        case (op)
            OPC_STREAM, OPC_STREAM_CTXS: begin
                dec.kind = INV_STREAM;
            end
            OPC_CONTEXT: begin
                dec.kind = INV_CONTEXT;
            end
            OPC_STREAM_BLOCK: begin
                if (range_is_every(rng)) begin
                    dec.kind  = INV_EVERY;
                    first_sid = '0;
                    last_sid  = '0;
                end else begin
                    dec.kind  = INV_STREAM;
                    first_sid = sid & ~blk_mask;
                    last_sid  = sid | blk_mask;
                end
            end
            default: begin
                dec.known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cfgi_seq.sv
module cfgi_seq
    import cfgi_pkg::*;
#(
    parameter int SID_W  = 8,
    parameter int SSID_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  inv_kind_e         start_kind,
    input  logic [SID_W-1:0]  start_first,
    input  logic [SID_W-1:0]  start_last,
    input  logic [SSID_W-1:0] start_ssid,
    input  logic              all_ready,
    output logic              busy,
    output inv_kind_e         kind_q,
    output logic [SID_W-1:0]  cur_sid,
    output logic [SSID_W-1:0] ssid_q
);

    logic [SID_W-1:0] end_sid;
    logic             fire;
    logic             at_end;

    assign fire   = busy && all_ready;
    assign at_end = (cur_sid == end_sid);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            kind_q  <= INV_STREAM;
            cur_sid <= '0;
            end_sid <= '0;
            ssid_q  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            kind_q  <= start_kind;
            cur_sid <= start_first;
            end_sid <= start_last;
            ssid_q  <= (start_kind == INV_CONTEXT) ? start_ssid : '0;
        end else if (fire) begin
            if (at_end) begin
                busy <= 1'b0;
            end else begin
                cur_sid <= cur_sid + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgi_dispatch.sv
module cfgi_dispatch
    import cfgi_pkg::*;
#(
    parameter int SID_W     = 8,
    parameter int SSID_W    = 8,
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [7:0]           cmd_op,
    input  logic [SID_W-1:0]     cmd_sid,
    input  logic [SSID_W-1:0]    cmd_ssid,
    input  logic [4:0]           cmd_range,
    output logic                 inv_valid,
    output logic [1:0]           inv_kind,
    output logic [SID_W-1:0]     inv_sid,
    output logic [SSID_W-1:0]    inv_ssid,
    input  logic [2*NUM_PORTS:0] tgt_ready,
    output logic                 cmd_err
);

    localparam int NUM_TGT = 2 * NUM_PORTS + 1;

    cfgi_dec_t        dec;
    logic [SID_W-1:0] first_sid;
    logic [SID_W-1:0] last_sid;
    logic             accept;
    logic             start;
    logic             all_ready;
    logic             busy;
    inv_kind_e        kind_q;

    assign all_ready = (tgt_ready == {NUM_TGT{1'b1}});

    cfgi_decode #(.SID_W(SID_W)) u_dec (
        .op        (cmd_op),
        .sid       (cmd_sid),
        .rng       (cmd_range),
        .dec       (dec),
        .first_sid (first_sid),
        .last_sid  (last_sid)
    );

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign start     = accept && dec.known;

    cfgi_seq #(.SID_W(SID_W), .SSID_W(SSID_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_kind  (dec.kind),
        .start_first (first_sid),
        .start_last  (last_sid),
        .start_ssid  (cmd_ssid),
        .all_ready   (all_ready),
        .busy        (busy),
        .kind_q      (kind_q),
        .cur_sid     (inv_sid),
        .ssid_q      (inv_ssid)
    );

    assign inv_valid = busy;
    assign inv_kind  = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= accept && !dec.known;
        end
    end

endmodule

// File: rtl/cfgi_dispatch_chk.sv
module cfgi_dispatch_chk #(
    parameter int SID_W     = 8,
    parameter int SSID_W    = 8,
    parameter int NUM_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 inv_valid,
    input logic [1:0]           inv_kind,
    input logic [SID_W-1:0]     inv_sid,
    input logic [SSID_W-1:0]    inv_ssid,
    input logic [2*NUM_PORTS:0] tgt_ready,
    input logic                 cmd_err
);

    logic all_rdy;
    assign all_rdy = &tgt_ready;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!inv_valid && cmd_ready && !cmd_err));

    p_ctx_single_r3: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_kind == 2'd1 && all_rdy) |=> !inv_valid);

    p_block_step_r5: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && all_rdy) |=> (!inv_valid || inv_sid == $past(inv_sid) + 1'b1));

    p_every_single_r6: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && inv_kind == 2'd2 && all_rdy) |=> !inv_valid);

    p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !all_rdy) |=>
            (inv_valid && $stable(inv_kind) && $stable(inv_sid) && $stable(inv_ssid)));

    p_accept_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (inv_valid || cmd_err));

    p_err_no_req_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (!inv_valid && cmd_ready));

endmodule

bind cfgi_dispatch cfgi_dispatch_chk #(
    .SID_W(SID_W), .SSID_W(SSID_W), .NUM_PORTS(NUM_PORTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .inv_valid (inv_valid),
    .inv_kind  (inv_kind),
    .inv_sid   (inv_sid),
    .inv_ssid  (inv_ssid),
    .tgt_ready (tgt_ready),
    .cmd_err   (cmd_err)
);

// File: tb/sim_cfgi_dispatch.sv
`timescale 1ns/1ps
module sim_cfgi_dispatch;

    localparam int SID_W     = 8;
    localparam int SSID_W    = 8;
    localparam int NUM_PORTS = 2;
    localparam int NT        = 2 * NUM_PORTS + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [7:0]        cmd_op = '0;
    logic [SID_W-1:0]  cmd_sid = '0;
    logic [SSID_W-1:0] cmd_ssid = '0;
    logic [4:0]        cmd_range = '0;
    logic              inv_valid;
    logic [1:0]        inv_kind;
    logic [SID_W-1:0]  inv_sid;
    logic [SSID_W-1:0] inv_ssid;
    logic [NT-1:0]     tgt_ready = '1;
    logic              cmd_err;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    bit  rand_rdy = 0;

    always #4 clk = ~clk;

    cfgi_dispatch #(.SID_W(SID_W), .SSID_W(SSID_W), .NUM_PORTS(NUM_PORTS)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sid(cmd_sid), .cmd_ssid(cmd_ssid), .cmd_range(cmd_range),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_sid(inv_sid), .inv_ssid(inv_ssid),
        .tgt_ready(tgt_ready), .cmd_err(cmd_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit op_known(input logic [7:0] op);
        return op == 8'h03 || op == 8'h04 || op == 8'h05 || op == 8'h06;
    endfunction

    function automatic int exp_count(input logic [7:0] op, input int rng);
        if (op != 8'h04 || rng == 31) return 1;
        if (rng + 1 >= SID_W) return 1 << SID_W;
        return 1 << (rng + 1);
    endfunction

    function automatic int exp_base(input logic [7:0] op, input int sid, input int rng);
        int n;
        n = exp_count(op, rng);
        return sid & ~(n - 1);
    endfunction

    function automatic int exp_kind(input logic [7:0] op, input int rng);
        if (op == 8'h05) return 1;
        if (op == 8'h04 && rng == 31) return 2;
        return 0;
    endfunction

    function automatic string req_of(input logic [7:0] op, input int rng);
        if (op == 8'h03) return "R2";
        if (op == 8'h05) return "R3";
        if (op == 8'h06) return "R4";
        if (rng == 31)   return "R6";
        return "R5";
    endfunction

    task automatic drive_ready();
        if (rand_rdy) begin
            for (int b = 0; b < NT; b++) tgt_ready[b] = ($urandom % 4) != 0;
        end else begin
            tgt_ready = '1;
        end
    endtask

    // Called at a falling edge with the dispatcher idle.
    task automatic run_cmd(input logic [7:0] op, input int sid, input int ssid, input int rng);
        int    n, base, kind, idx;
        bit    fire;
        string rq;
        n    = exp_count(op, rng);
        base = exp_base(op, sid, rng);
        kind = exp_kind(op, rng);
        rq   = req_of(op, rng);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_sid   = SID_W'(sid);
        cmd_ssid  = SSID_W'(ssid);
        cmd_range = 5'(rng);
        drive_ready();
        check(cmd_ready == 1'b1, "R8", "ready before accept", cmd_ready, 1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!op_known(op)) begin
            check(cmd_err == 1'b1, "R9", "error pulse", cmd_err, 1);
            check(inv_valid == 1'b0, "R9", "no request", inv_valid, 0);
            check(cmd_ready == 1'b1, "R9", "still ready", cmd_ready, 1);
            @(negedge clk);
            check(cmd_err == 1'b0, "R9", "pulse ends", cmd_err, 0);
            check(inv_valid == 1'b0, "R9", "no late request", inv_valid, 0);
            return;
        end
        check(cmd_err == 1'b0, "R9", "no error on valid op", cmd_err, 0);
        idx = 0;
        while (idx < n) begin
            drive_ready();
            check(inv_valid == 1'b1, "R7", "request offered", inv_valid, 1);
            check(cmd_ready == 1'b0, "R8", "busy hold-off", cmd_ready, 0);
            check(int'(inv_kind) == kind, rq, "kind", inv_kind, kind);
            if (kind != 2)
                check(int'(inv_sid) == base + idx, rq, "stream id", inv_sid, base + idx);
            if (kind == 1)
                check(int'(inv_ssid) == ssid, rq, "substream id", inv_ssid, ssid);
            fire = &tgt_ready;
            @(posedge clk);
            @(negedge clk);
            if (fire) idx++;
        end
        check(inv_valid == 1'b0, rq, "exactly the expected requests", inv_valid, 0);
        check(cmd_ready == 1'b1, "R8", "ready after last", cmd_ready, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
        check(inv_valid == 1'b0, "R1", "reset valid", inv_valid, 0);
        check(cmd_err == 1'b0, "R1", "reset err", cmd_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check(inv_valid == 1'b0 && cmd_ready == 1'b1, "R1", "after reset", inv_valid, 0);

        // Directed cases
        rand_rdy = 0;
        run_cmd(8'h03, 8'h5a, 0, 0);          // R2
        run_cmd(8'h05, 8'h21, 8'h9c, 0);      // R3
        run_cmd(8'h06, 8'h77, 0, 0);          // R4
        run_cmd(8'h04, 8'h35, 0, 0);          // R5 two streams at odd id
        run_cmd(8'h04, 8'h9b, 0, 3);          // R5 sixteen streams
        run_cmd(8'h04, 8'h00, 0, 31);         // R6
        run_cmd(8'h00, 8'h11, 0, 0);          // R9
        run_cmd(8'hff, 8'h11, 0, 0);          // R9
        rand_rdy = 1;
        run_cmd(8'h04, 8'hc3, 0, 7);          // R5 whole space with stalls (R7)
        run_cmd(8'h04, 8'h12, 0, 30);         // R5 saturating range
        run_cmd(8'h04, 8'h00, 0, 31);         // R6 under stalls
        run_cmd(8'h05, 8'h01, 8'h44, 0);      // R3 under stalls

        // Random mix
        for (int k = 0; k < 60; k++) begin
            logic [7:0] op;
            int sel, rng;
            sel = $urandom % 6;
            case (sel)
                0: op = 8'h03;
                1: op = 8'h04;
                2: op = 8'h05;
                3: op = 8'h06;
                default: begin
                    op = 8'($urandom);
                    if (op_known(op)) op = op ^ 8'h80;
                end
            endcase
            rng = (($urandom % 5) == 0) ? 31 : int'($urandom % 6);
            rand_rdy = ($urandom % 2) == 1;
            run_cmd(op, int'($urandom % 256), int'($urandom % 256), rng);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule